// File: doc/BRIEF.md
# Lane alignment transmit sequencer

This block is the transmit-side link-layer sequencer for one serial converter lane. It produces one octet per clock, plus a flag that marks the octet as a control character, ready for an 8b/10b encoder. The receiver drives an active-low synchronisation request, `sync_n`. While the request is low, the lane carries nothing but comma characters. Once the request is released, the block waits for the next boundary of its local multi-frame clock. It then sends a four-multi-frame alignment sequence, which lets the receiver check frame alignment, the lane mapping and the link configuration. After the sequence it forwards user octets unchanged.

The local multi-frame clock is a counter of `OCT_PER_FRAME * FRAMES_PER_MF` octets. It starts at phase 0 when reset is released and advances by one every clock. Link configuration values are parameters. They are sent in a fixed layout inside the second multi-frame of the alignment sequence. A new synchronisation request aborts the alignment sequence or the data phase at once and returns the lane to commas. `sync_n` is taken as already synchronous to `clk`. The multi-frame length must be at least 10 octets.

Top module: `lane_align_tx`

## Requirements
- R1: While `rst_n` is low, the output is the comma K28.5 (`tx_octet` = 0xBC, `tx_is_k` = 1), whatever `sync_n` and `din` are. The multi-frame phase restarts at 0 on the first clock after reset.
- R2: When `sync_n` is sampled low at a rising edge, the output from that edge on is the comma 0xBC with `tx_is_k` = 1, in every state.
- R3: After `sync_n` goes high, commas continue until the edge at which the multi-frame phase is MFL-1. The first alignment octet appears when the phase is 0. MFL = `OCT_PER_FRAME*FRAMES_PER_MF`, and the phase is the number of clocks since reset release, modulo MFL.
- R4: The alignment sequence lasts exactly 4 multi-frames. Octet 0 of each is K28.0 (0x1C, `tx_is_k` = 1) and octet MFL-1 of each is K28.3 (0x7C, `tx_is_k` = 1).
- R5: Octet 1 of multi-frame 1 (counting from 0) is K28.4 (0x9C, `tx_is_k` = 1).
- R6: Octets 2 to 8 of multi-frame 1 are data octets (`tx_is_k` = 0), in this order:
  - octet 2: device id;
  - octet 3: {scramble, 2'b00, lane id[4:0]};
  - octet 4: octets per frame minus 1;
  - octet 5: {3'b000, frames per multi-frame minus 1};
  - octet 6: {high density, 2'b00, lanes minus 1};
  - octet 7: {subclass[2:0], resolution minus 1};
  - octet 8: {version[2:0], bits per sample minus 1}.
  
  With the defaults these are A5, 83, 01, 07, 03, 2D, 2F.
- R7: Every other octet of the sequence is a data octet whose value is (m*MFL + p) mod 256, where m is the multi-frame number (0 to 3) and p is the octet position within the multi-frame.
- R8: After the fourth multi-frame, `tx_octet` follows `din` within the same cycle, with `tx_is_k` = 0. Only the four control values 0xBC, 0x1C, 0x7C and 0x9C ever appear with `tx_is_k` = 1.
- R9: A request raised during the alignment sequence or the data phase gives commas from the next edge on. After release, a complete sequence restarts from multi-frame 0 on the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Receiver synchronisation request, active low |
| din | input | 8 | User octet for the data phase |
| tx_octet | output | 8 | Octet to the line encoder |
| tx_is_k | output | 1 | Marks `tx_octet` as a control character |

## Verification
Releases of `sync_n` at scattered multi-frame phases show whether the sequence is gated by the multi-frame clock rather than by the moment of release. Releases exactly at the last phase and at phase 0 separate "next boundary" from "one multi-frame later". Requests raised in the middle of the configuration multi-frame and in the data phase, including requests one cycle long, show whether the abort is immediate and whether the restart begins again at multi-frame 0. A long run of random request toggles with random user octets is compared cycle by cycle against a bench model of the expected output.

// File: rtl/lane_align_tx.sv
module lane_align_tx #(
  parameter int          OCT_PER_FRAME = 2,
  parameter int          FRAMES_PER_MF = 8,
  parameter logic [7:0]  DEV_ID        = 8'hA5,
  parameter int          LANE_ID       = 3,
  parameter int          LANE_CNT      = 4,
  parameter int          RES_BITS      = 14,
  parameter int          SAMPLE_BITS   = 16,
  parameter bit          SCR_EN        = 1'b1,
  parameter bit          HI_DENS       = 1'b0,
  parameter int          VERSION       = 1,
  parameter int          SUBCLASS      = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_n,
  input  logic [7:0] din,
  output logic [7:0] tx_octet,
  output logic       tx_is_k
);
  localparam int MFL = OCT_PER_FRAME * FRAMES_PER_MF;
  localparam int LCW = (MFL > 1) ? $clog2(MFL) : 1;
  localparam logic [LCW-1:0] LC_LAST = LCW'(MFL - 1);

  localparam logic [7:0] K_COMMA   = 8'hBC;
  localparam logic [7:0] K_MFSTART = 8'h1C;
  localparam logic [7:0] K_MFEND   = 8'h7C;
  localparam logic [7:0] K_CFG     = 8'h9C;

  localparam logic [7:0] CFG_DEV  = DEV_ID;
  localparam logic [7:0] CFG_LANE = {SCR_EN, 2'b00, 5'(LANE_ID)};
  localparam logic [7:0] CFG_F    = 8'(OCT_PER_FRAME - 1);
  localparam logic [7:0] CFG_K    = {3'b000, 5'(FRAMES_PER_MF - 1)};
  localparam logic [7:0] CFG_L    = {HI_DENS, 2'b00, 5'(LANE_CNT - 1)};
  localparam logic [7:0] CFG_N    = {3'(SUBCLASS), 5'(RES_BITS - 1)};
  localparam logic [7:0] CFG_NP   = {3'(VERSION), 5'(SAMPLE_BITS - 1)};

  typedef enum logic [1:0] {ST_COMMA, ST_ALIGN, ST_DATA} st_t;

  st_t            st;
  logic [LCW-1:0] lc;
  logic [1:0]     mf;
  logic           at_last;
  logic [7:0]     seq_cnt;

  assign at_last = (lc == LC_LAST);
  assign seq_cnt = 8'(mf) * 8'(MFL) + 8'(lc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc <= '0;
      mf <= '0;
      st <= ST_COMMA;
    end else begin
      lc <= at_last ? '0 : lc + 1'b1;
      if (!sync_n) begin
        st <= ST_COMMA;
        mf <= '0;
      end else begin
        case (st)
          ST_COMMA: if (at_last) begin
            st <= ST_ALIGN;
            mf <= '0;
          end
          ST_ALIGN: if (at_last) begin
            mf <= mf + 2'd1;
            if (mf == 2'd3) st <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    tx_is_k  = 1'b0;
    tx_octet = din;
    case (st)
      ST_COMMA: begin
        tx_is_k  = 1'b1;
        tx_octet = K_COMMA;
      end
      ST_ALIGN: begin
        tx_octet = seq_cnt;
        if (lc == '0) begin
          tx_is_k  = 1'b1;
          tx_octet = K_MFSTART;
        end else if (at_last) begin
          tx_is_k  = 1'b1;
          tx_octet = K_MFEND;
        end else if (mf == 2'd1) begin
          case (int'(lc))
            1: begin
              tx_is_k  = 1'b1;
              tx_octet = K_CFG;
            end
            2: tx_octet = CFG_DEV;
            3: tx_octet = CFG_LANE;
            4: tx_octet = CFG_F;
            5: tx_octet = CFG_K;
            6: tx_octet = CFG_L;
            7: tx_octet = CFG_N;
            8: tx_octet = CFG_NP;
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_align_tx_chk.sv
module lane_align_tx_chk #(
  parameter int MF_LEN = 16,
  parameter int LC_W   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sync_n,
  input logic [7:0]      tx_octet,
  input logic            tx_is_k,
  input logic [LC_W-1:0] lc
);
  logic is_comma, is_start, is_end, is_cfg;
  assign is_comma = tx_is_k && (tx_octet == 8'hBC);
  assign is_start = tx_is_k && (tx_octet == 8'h1C);
  assign is_end   = tx_is_k && (tx_octet == 8'h7C);
  assign is_cfg   = tx_is_k && (tx_octet == 8'h9C);

  assert_comma_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> is_comma);

  assert_release_before_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_comma && $past(is_comma)) |-> $past(sync_n));

  assert_start_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_start |-> (lc == '0));

  assert_end_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_end |-> (lc == LC_W'(MF_LEN - 1)));

  assert_cfg_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_cfg |-> $past(is_start));

  assert_ctrl_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_is_k |-> (is_comma || is_start || is_end || is_cfg));
endmodule

bind lane_align_tx lane_align_tx_chk #(.MF_LEN(MFL), .LC_W(LCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
  .tx_octet(tx_octet), .tx_is_k(tx_is_k), .lc(lc)
);

// File: tb/tb_lane_align_tx.sv
module tb_lane_align_tx;
  localparam int CLK_PERIOD = 10;
  localparam int MFL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] tx_octet;
  logic       tx_is_k;

  int n_chk = 0;
  int n_fail = 0;

  int m_lc = 0, m_mf = 0, m_st = 0;
  bit m_sy = 1'b1, m_re = 1'b0;

  lane_align_tx dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .din(din),
    .tx_octet(tx_octet), .tx_is_k(tx_is_k)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model of the state, built from R2, R3, R4 and R9
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lc <= 0; m_mf <= 0; m_st <= 0; m_sy <= 1'b1; m_re <= 1'b0;
    end else begin
      m_lc <= (m_lc + 1) % MFL;
      m_sy <= sync_n;
      if (!sync_n) begin
        if (m_st != 0) m_re <= 1'b1;
        m_st <= 0; m_mf <= 0;
      end else if (m_st == 0 && m_lc == MFL - 1) begin
        m_st <= 1; m_mf <= 0; m_re <= 1'b0;
      end else if (m_st == 1 && m_lc == MFL - 1) begin
        if (m_mf == 3) m_st <= 2;
        m_mf <= m_mf + 1;
      end
    end
  end

  function automatic logic [8:0] exp_out(int st, int mf, int p, logic [7:0] d);
    logic [7:0] cfg [7];
    cfg = '{8'hA5, 8'h83, 8'h01, 8'h07, 8'h03, 8'h2D, 8'h2F};
    if (st == 0) return {1'b1, 8'hBC};
    if (st == 2) return {1'b0, d};
    if (p == 0) return {1'b1, 8'h1C};
    if (p == MFL - 1) return {1'b1, 8'h7C};
    if (mf == 1 && p == 1) return {1'b1, 8'h9C};
    if (mf == 1 && p >= 2 && p <= 8) return {1'b0, cfg[p-2]};
    return {1'b0, 8'((mf * MFL + p) % 256)};
  endfunction

  function automatic string req_tag(int st, int mf, int p, bit sy, bit re);
    if (st == 0) return re ? "R9" : (!sy ? "R2" : "R3");
    if (st == 2) return "R8";
    if (p == 0 || p == MFL - 1) return "R4";
    if (mf == 1 && p == 1) return "R5";
    if (mf == 1 && p >= 2 && p <= 8) return "R6";
    return "R7";
  endfunction

  task automatic check_now(string tag);
    logic [8:0] e;
    e = rst_n ? exp_out(m_st, m_mf, m_lc, din) : {1'b1, 8'hBC};
    n_chk++;
    if ({tx_is_k, tx_octet} !== e) begin
      n_fail++;
      $display("FAIL %s t=%0t actual k=%0b oct=%02h expected k=%0b oct=%02h",
               tag, $time, tx_is_k, tx_octet, e[8], e[7:0]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_now(req_tag(m_st, m_mf, m_lc, m_sy, m_re));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      din = 8'($urandom);
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R3 actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset dominates a released request and user data
    sync_n = 1'b1;
    din = 8'h5A;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_now("R1");
    end
    sync_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: held request gives commas only
    run(23);

    // R3..R8: release at an odd phase, full sequence and data
    sync_n = 1'b1;
    run(5 * MFL + 30);

    // R8: data follows din within the cycle
    for (int i = 0; i < 4; i++) begin
      din = 8'($urandom);
      #1;
      check_now("R8");
    end

    // R9: abort in the middle of the configuration multi-frame
    sync_n = 1'b0;
    run(3);
    sync_n = 1'b1;
    while (!(m_st == 1 && m_mf == 1 && m_lc == 5)) run(1);
    sync_n = 1'b0;
    run(3);
    sync_n = 1'b1;
    run(6 * MFL);

    // R3: release exactly at the last phase, then exactly at phase 0
    sync_n = 1'b0;
    run(2);
    while (m_lc != MFL - 1) run(1);
    sync_n = 1'b1;
    run(2 * MFL);
    sync_n = 1'b0;
    run(2);
    while (m_lc != 0) run(1);
    sync_n = 1'b1;
    run(6 * MFL);

    // R9: one-cycle request during data
    while (m_st != 2) run(1);
    run(7);
    sync_n = 1'b0;
    run(1);
    sync_n = 1'b1;
    run(6 * MFL);

    // random request toggling
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 3) sync_n = ~sync_n;
      run(1);
    end
    sync_n = 1'b1;
    run(6 * MFL);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule